// File: doc/BRIEF.md
# Dual-Loop Out-of-Lock Detector

This block watches the phase-error pulses of two phase-locked loops (A and B) and keeps one out-of-lock flag per loop. It measures each error pulse in cycles of a fast sampling clock. A pulse longer than a set threshold raises the flag for that loop. The flag drops only after one full reference cycle has passed with every error pulse at or under the threshold. Each loop marks the start of its reference cycles with a one-cycle strobe.

A 2-bit select decides what drives one shared open-drain pin. The pin can show a plain port bit, the status of loop B, the status of loop A, or the OR of both flags. The block outputs the gate drive of the pull-down transistor, where 1 means the transistor is on and the pin is pulled low. A loop that is powered down has its flag forced clear.

Top module: `lock_flag_mux`

## Requirements
- R1: While a loop is powered, an error pulse that stays high for more than THRESH consecutive sampling cycles sets that loop's flag in the cycle after the (THRESH+1)-th high cycle. A pulse of exactly THRESH cycles does not set the flag.
- R2: A set flag is cleared in the cycle after the reference strobe that closes a complete reference cycle with no over-threshold error. A complete cycle is the span between two strobes. The first strobe after reset or power-up only opens a cycle.
- R3: A reference cycle that contains an over-threshold error does not clear the flag, even if the flag was already set.
- R4: During and right after reset, both flags read 1 (out-of-lock).
- R5: While a loop's power input is 0, its flag reads 0 from the next cycle onward, whatever its error input does.
- R6: With select 2'b00, the pull-down drive equals the inverse of the port bit, so a port bit of 1 leaves the pin at high impedance.
- R7: With select 2'b01, the pull-down drive follows the flag of loop B. With select 2'b10, it follows the flag of loop A.
- R8: With select 2'b11, the pull-down drive is the OR of both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_a | input | 1 | Phase-error pulse, loop A |
| err_b | input | 1 | Phase-error pulse, loop B |
| ref_a | input | 1 | One-cycle strobe that starts each reference cycle, loop A |
| ref_b | input | 1 | One-cycle strobe that starts each reference cycle, loop B |
| pwr_a | input | 1 | Loop A powered (0 = down) |
| pwr_b | input | 1 | Loop B powered (0 = down) |
| sel | input | 2 | Pin source: 00 port, 01 B, 10 A, 11 OR |
| port_bit | input | 1 | Port bit shown in port mode (1 = high impedance) |
| pin_pull | output | 1 | Pull-down transistor on (pin driven low) |
| ool_a | output | 1 | Out-of-lock flag, loop A |
| ool_b | output | 1 | Out-of-lock flag, loop B |

## Verification
The bench builds the block with THRESH = 4. This keeps the pulse widths just under, at and over the threshold short, and lets random error pulses of 1 to 8 cycles fall on both sides of the threshold often. Reference cycles of about 20 cycles let many release and re-set sequences happen in a short run. Random power-down and select changes are mixed in with these.

// File: rtl/lock_flag_mux.sv
module lock_flag_mux #(
  parameter int THRESH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_a,
  input  logic       err_b,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       pwr_a,
  input  logic       pwr_b,
  input  logic [1:0] sel,
  input  logic       port_bit,
  output logic       pin_pull,
  output logic       ool_a,
  output logic       ool_b
);
  localparam int CW = $clog2(THRESH + 1);

  logic [1:0] err, strobe, pwr, ool;

  assign err    = {err_b, err_a};
  assign strobe = {ref_b, ref_a};
  assign pwr    = {pwr_b, pwr_a};

  for (genvar g = 0; g < 2; g++) begin : g_loop
    logic [CW-1:0] run;
    logic          armed, dirty, wide;

    assign wide = err[g] && (run == CW'(THRESH));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run    <= '0;
        armed  <= 1'b0;
        dirty  <= 1'b0;
        ool[g] <= 1'b1;
      end else if (!pwr[g]) begin
        run    <= '0;
        armed  <= 1'b0;
        dirty  <= 1'b0;
        ool[g] <= 1'b0;
      end else begin
        if (!err[g])                 run <= '0;
        else if (run != CW'(THRESH)) run <= run + 1'b1;

        if (wide)                              ool[g] <= 1'b1;
        else if (strobe[g] && armed && !dirty) ool[g] <= 1'b0;

        if (strobe[g]) begin
          armed <= 1'b1;
          dirty <= wide;
        end else if (wide) begin
          dirty <= 1'b1;
        end
      end
    end
  end

  assign ool_a = ool[0];
  assign ool_b = ool[1];

  always_comb begin
    case (sel)
      2'b00:   pin_pull = ~port_bit;
      2'b01:   pin_pull = ool_b;
      2'b10:   pin_pull = ool_a;
      default: pin_pull = ool_a | ool_b;
    endcase
  end
endmodule

// File: rtl/lock_flag_mux_chk.sv
module lock_flag_mux_chk #(
  parameter int THRESH = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       err_a,
  input logic       err_b,
  input logic       ref_a,
  input logic       pwr_a,
  input logic       pwr_b,
  input logic [1:0] sel,
  input logic       port_bit,
  input logic       pin_pull,
  input logic       ool_a,
  input logic       ool_b
);
  int unsigned hi_a, hi_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_a <= 0;
      hi_b <= 0;
    end else begin
      hi_a <= (err_a && pwr_a) ? hi_a + 1 : 0;
      hi_b <= (err_b && pwr_b) ? hi_b + 1 : 0;
    end
  end

  assert_set_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_a && err_a && hi_a >= THRESH) |=> ool_a);
  assert_set_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_b && err_b && hi_b >= THRESH) |=> ool_b);
  assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ool_a) |-> ($past(ref_a) || !$past(pwr_a)));
  assert_pwrdn_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_a |=> !ool_a);
  assert_pwrdn_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_b |=> !ool_b);
  assert_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00 && port_bit) |-> !pin_pull);
  assert_loop_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10 && ool_a) |-> pin_pull);
  assert_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11 && !ool_a && !ool_b) |-> !pin_pull);
endmodule

bind lock_flag_mux lock_flag_mux_chk #(.THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_a(err_a), .err_b(err_b), .ref_a(ref_a),
  .pwr_a(pwr_a), .pwr_b(pwr_b), .sel(sel), .port_bit(port_bit),
  .pin_pull(pin_pull), .ool_a(ool_a), .ool_b(ool_b)
);

// File: tb/lock_flag_mux_tb.sv
module lock_flag_mux_tb;
  localparam int TH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic err_a = 0, err_b = 0, ref_a = 0, ref_b = 0, pwr_a = 1, pwr_b = 1;
  logic [1:0] sel = 2'b00;
  logic port_bit = 1'b1;
  logic pin_pull, ool_a, ool_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lock_flag_mux #(.THRESH(TH)) u_dut (
    .clk(clk), .rst_n(rst_n), .err_a(err_a), .err_b(err_b), .ref_a(ref_a),
    .ref_b(ref_b), .pwr_a(pwr_a), .pwr_b(pwr_b), .sel(sel),
    .port_bit(port_bit), .pin_pull(pin_pull), .ool_a(ool_a), .ool_b(ool_b)
  );

  // reference model, written from the requirements
  int  mrun [2];
  bit  marm [2], mdirty [2], mool [2];

  always @(posedge clk) begin
    logic [1:0] e, r, p;
    e = {err_b, err_a}; r = {ref_b, ref_a}; p = {pwr_b, pwr_a};
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        mrun[i] <= 0; marm[i] <= 0; mdirty[i] <= 0; mool[i] <= 1;
      end else if (!p[i]) begin
        mrun[i] <= 0; marm[i] <= 0; mdirty[i] <= 0; mool[i] <= 0;
      end else begin
        bit over;
        over = e[i] && (mrun[i] + 1 > TH);
        mrun[i] <= e[i] ? mrun[i] + 1 : 0;
        if (over) mool[i] <= 1;
        else if (r[i] && marm[i] && !mdirty[i]) mool[i] <= 0;
        if (r[i]) begin marm[i] <= 1; mdirty[i] <= over; end
        else if (over) mdirty[i] <= 1;
      end
    end
  end

  function automatic bit exp_pin(logic [1:0] s, logic pb, bit a, bit b);
    if (s == 2'b00) return !pb;
    if (s == 2'b01) return b;
    if (s == 2'b10) return a;
    return a | b;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      if (rst_n) begin
        check("R1/R2/R3/R5 model flag A", ool_a, mool[0]);
        check("R1/R2/R3/R5 model flag B", ool_b, mool[1]);
        check("R6/R7/R8 model pin", pin_pull, exp_pin(sel, port_bit, mool[0], mool[1]));
      end
    end
  endtask

  task automatic strobe();
    ref_a = 1; ref_b = 1; step(1); ref_a = 0; ref_b = 0; step(1);
  endtask

  task automatic pulse_a(int w);
    err_a = 1; step(w); err_a = 0; step(1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    int ra, rb, gap;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check("R4 reset flag A", ool_a, 1);
    check("R4 reset flag B", ool_b, 1);
    check("R6 port 1 hi-z", pin_pull, 0);
    rst_n = 1;
    step(2);
    check("R4 after reset A", ool_a, 1);
    strobe();
    check("R2 first strobe only opens", ool_a, 1);
    step(5);
    strobe();
    check("R2 clean cycle clears A", ool_a, 0);
    check("R2 clean cycle clears B", ool_b, 0);
    pulse_a(TH);
    check("R1 width at threshold", ool_a, 0);
    pulse_a(TH + 1);
    check("R1 width over threshold", ool_a, 1);
    strobe();
    check("R3 dirty cycle keeps flag", ool_a, 1);
    step(3); pulse_a(TH + 2); step(2);
    strobe();
    check("R3 wide error in cycle", ool_a, 1);
    step(6);
    strobe();
    check("R2 release after clean cycle", ool_a, 0);
    pulse_a(TH + 1);
    sel = 2'b10; step(1); check("R7 select A", pin_pull, 1);
    sel = 2'b01; step(1); check("R7 select B", pin_pull, 0);
    sel = 2'b11; step(1); check("R8 OR", pin_pull, 1);
    sel = 2'b00; port_bit = 0; step(1); check("R6 port 0 drives low", pin_pull, 1);
    pwr_a = 0; step(1);
    check("R5 power-down clears", ool_a, 0);
    err_a = 1; step(TH + 3); err_a = 0;
    check("R5 error ignored while down", ool_a, 0);
    pwr_a = 1; step(1);
    // random phase
    ra = 0; rb = 0; gap = 0;
    for (int c = 0; c < 4000; c++) begin
      if (ra == 0 && $urandom_range(0, 9) == 0) ra = $urandom_range(1, 8);
      if (rb == 0 && $urandom_range(0, 9) == 0) rb = $urandom_range(1, 8);
      err_a = ra > 0; if (ra > 0) ra--;
      err_b = rb > 0; if (rb > 0) rb--;
      gap++;
      ref_a = (gap >= 18 && $urandom_range(0, 3) == 0);
      ref_b = ref_a;
      if (ref_a) gap = 0;
      if ($urandom_range(0, 99) < 2) pwr_a = ~pwr_a;
      if ($urandom_range(0, 99) < 2) pwr_b = ~pwr_b;
      sel = 2'($urandom_range(0, 3));
      port_bit = 1'($urandom_range(0, 1));
      step(1);
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end
endmodule